// File: doc/BRIEF.md
# Two-Stage Pipelined Synchronous Memory Read Path

This block is a word-addressed synchronous memory whose read path is split over two clock cycles. In the first cycle the requested row is selected and its stored word is driven onto the bit lines. The edge that ends that cycle captures the bit-line value. In the second cycle a sense stage resolves the word, and the next rising edge strobes it into the output register. A new read can be issued in every cycle, so up to two reads overlap inside the pipeline.

A write shares the address port with reads and commits at the clock edge that ends its cycle. A write issued together with a read, or one cycle after it, to the same row does not change the data that the read returns. The read always delivers the contents the row held when the read was issued. Storage is a plain array of registers. Only the cycle timing of word-line selection and sensing is modelled.

Top module: `pipe_sram_read`

## Requirements
- R1: While reset is asserted, and in the first cycle after its release, `rvalid` is low and `rdata` is zero.
- R2: `rvalid` is high in a cycle exactly when `ren` was high two cycles earlier.
- R3: In a cycle with `rvalid` high, `rdata` equals the word stored at the address presented with the matching read, as it was before any write in that issue cycle.
- R4: Reads issued on consecutive cycles complete on consecutive cycles, in issue order, with no stall.
- R5: A read and a write to the same address in the same cycle return the old word; the new word is visible to later reads.
- R6: A write to an address in the cycle after a read of that address does not alter the read's result.
- R7: In any cycle with `rvalid` low, `rdata` keeps the value it had in the previous cycle.
- R8: A write with `wen` high stores `wdata` at `addr` at the end of its cycle, and a read issued in the next cycle returns it.
- R9: A read with `wen` low leaves the stored contents unchanged, whatever `wdata` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ren | input | 1 | Read request for `addr`; accepted in every cycle |
| wen | input | 1 | Write request for `addr` with `wdata` |
| addr | input | ADDR_W | Word address shared by reads and writes |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid when `rvalid` is high |
| rvalid | output | 1 | High two cycles after an accepted read |

## Verification
The assertions check the timing skeleton on every cycle. They confirm that a request reaches the word-line stage one edge later and the output one edge after that. They also confirm that nothing emerges in the first cycles after reset and that the output register holds its value between completions. Data correctness needs the bench scenarios, which track the stored contents outside the design. These include full-array write and back-to-back read sweeps, same-cycle and next-cycle writes against in-flight reads, and reads that present junk write data without `wen`.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;

  localparam int unsigned PSR_DEF_DATA_W = 32;
  localparam int unsigned PSR_DEF_DEPTH  = 1024;

  // Address width needed for a given depth (at least one bit).
  function automatic int unsigned psr_addr_w(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

  typedef enum logic {
    STG_EMPTY = 1'b0,
    STG_FULL  = 1'b1
  } stage_state_e;

endpackage

// File: rtl/psr_cell_array.sv
module psr_cell_array
  import pipe_sram_pkg::*;
#(
  parameter int unsigned DATA_W = PSR_DEF_DATA_W,
  parameter int unsigned DEPTH  = PSR_DEF_DEPTH,
  parameter int unsigned ADDR_W = psr_addr_w(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wl_en,
  output logic [DATA_W-1:0] bitline
);

  logic [DEPTH-1:0]  wr_hit;
  logic [DEPTH-1:0]  wl_hit;
  logic [DATA_W-1:0] row_dout [DEPTH];

  // One row per word: row decode, write enable, and its storage register.
  for (genvar r = 0; r < DEPTH; r++) begin : g_row
    logic [DATA_W-1:0] cell_q;
    logic [DATA_W-1:0] cell_d;

    assign wr_hit[r] = wr_en && (addr == ADDR_W'(r));
    assign wl_hit[r] = wl_en && (addr == ADDR_W'(r));

    always_comb begin
      cell_d = cell_q;
      if (wr_hit[r]) cell_d = wr_data;
    end

    always_ff @(posedge clk) begin
      if (wr_hit[r]) cell_q <= cell_d;
    end

    assign row_dout[r] = cell_q;
  end

  // Bit lines carry a row only while its word line is raised.
  always_comb begin
    bitline = '0;
    for (int r = 0; r < DEPTH; r++) begin
      bitline = bitline | (row_dout[r] & {DATA_W{wl_hit[r]}});
    end
  end

endmodule

// File: rtl/psr_wordline_stage.sv
module psr_wordline_stage
  import pipe_sram_pkg::*;
#(
  parameter int unsigned DATA_W = PSR_DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [DATA_W-1:0] bitline,
  output logic              s1_vld,
  output logic [DATA_W-1:0] s1_data
);

  stage_state_e      state_q, state_d;
  logic [DATA_W-1:0] data_q, data_d;

  always_comb begin
    state_d = rd_req ? STG_FULL : STG_EMPTY;
    data_d  = data_q;
    if (rd_req) data_d = bitline;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= STG_EMPTY;
    else        state_q <= state_d;
  end

  // Data path register: clock-enabled, no reset.
  always_ff @(posedge clk) begin
    if (rd_req) data_q <= data_d;
  end

  assign s1_vld  = (state_q == STG_FULL);
  assign s1_data = data_q;

endmodule

// File: rtl/psr_sense_stage.sv
module psr_sense_stage
  import pipe_sram_pkg::*;
#(
  parameter int unsigned DATA_W = PSR_DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s1_vld,
  input  logic [DATA_W-1:0] s1_data,
  output logic              rd_vld,
  output logic [DATA_W-1:0] rd_data
);

  logic              vld_q, vld_d;
  logic [DATA_W-1:0] out_q, out_d;

  always_comb begin
    vld_d = s1_vld;
    out_d = out_q;
    if (s1_vld) out_d = s1_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      out_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (s1_vld) out_q <= out_d;
    end
  end

  assign rd_vld  = vld_q;
  assign rd_data = out_q;

endmodule

// File: rtl/pipe_sram_read.sv
module pipe_sram_read
  import pipe_sram_pkg::*;
#(
  parameter int unsigned DATA_W = PSR_DEF_DATA_W,
  parameter int unsigned DEPTH  = PSR_DEF_DEPTH,
  parameter int unsigned ADDR_W = psr_addr_w(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ren,
  input  logic              wen,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  logic [DATA_W-1:0] bitline;
  logic              s1_vld;
  logic [DATA_W-1:0] s1_data;

  psr_cell_array #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W)
  ) u_array (
    .clk     (clk),
    .wr_en   (wen),
    .addr    (addr),
    .wr_data (wdata),
    .wl_en   (ren),
    .bitline (bitline)
  );

  psr_wordline_stage #(
    .DATA_W (DATA_W)
  ) u_wl_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_req  (ren),
    .bitline (bitline),
    .s1_vld  (s1_vld),
    .s1_data (s1_data)
  );

  psr_sense_stage #(
    .DATA_W (DATA_W)
  ) u_sense_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .s1_vld  (s1_vld),
    .s1_data (s1_data),
    .rd_vld  (rvalid),
    .rd_data (rdata)
  );

endmodule

// File: rtl/psr_checker.sv
module psr_checker #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ren,
  input logic              s1_vld,
  input logic              rvalid,
  input logic [DATA_W-1:0] rdata
);

  // Edges seen since reset release, saturating at 2.
  logic [1:0] cyc_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cyc_q <= 2'd0;
    else if (cyc_q != 2'd2)  cyc_q <= cyc_q + 2'd1;
  end

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q != 2'd2) |-> !rvalid);

  assert_req_to_wordline_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ren |=> s1_vld);

  assert_no_req_no_wordline_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ren |=> !s1_vld);

  assert_two_cycle_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == 2'd2) |-> (rvalid == $past(ren, 2)));

  assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((cyc_q != 2'd0) && !rvalid) |-> $stable(rdata));

endmodule

bind pipe_sram_read psr_checker #(.DATA_W(DATA_W)) u_psr_checker (
  .clk    (clk),
  .rst_n  (rst_n),
  .ren    (ren),
  .s1_vld (s1_vld),
  .rvalid (rvalid),
  .rdata  (rdata)
);

// File: tb/pipe_sram_read_bench.sv
`timescale 1ns/1ps
module pipe_sram_read_bench;

  localparam int DW = 32;
  localparam int TB_DEPTH = 16;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ren, wen;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          rvalid;

  always #2 clk = ~clk;

  pipe_sram_read #(.DATA_W(DW), .DEPTH(TB_DEPTH), .ADDR_W(AW)) u_pipe_sram_read (
    .clk(clk), .rst_n(rst_n), .ren(ren), .wen(wen), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
  );

  int nchk = 0;
  int nbad = 0;
  logic [DW-1:0] model [TB_DEPTH];
  logic          pv;
  logic [DW-1:0] pd;
  string         ptag;
  logic [DW-1:0] held;
  bit            done = 0;

  function automatic logic [DW-1:0] patt(input int a, input int pass);
    return (DW'(a) * 32'h9E37_79B1) ^ (DW'(pass) << 28) ^ 32'h0000_5A5A;
  endfunction

  // One cycle: drive at the falling edge, check the read issued one step before.
  task automatic step(input logic r, input logic w, input int a,
                      input logic [DW-1:0] d, input string tg);
    logic          cv;
    logic [DW-1:0] cd;
    ren = r; wen = w; addr = AW'(a); wdata = d;
    cv = r;
    cd = model[a];
    if (w) model[a] = d;
    @(posedge clk);
    @(negedge clk);
    nchk++;
    if (rvalid !== pv) begin
      nbad++;
      $display("FAIL R2 rvalid actual=%0b expected=%0b", rvalid, pv);
    end
    nchk++;
    if (pv) begin
      if (rdata !== pd) begin
        nbad++;
        $display("FAIL %s rdata actual=%h expected=%h", ptag, rdata, pd);
      end
      held = pd;
    end else if (rdata !== held) begin
      nbad++;
      $display("FAIL R7 rdata actual=%h expected=%h", rdata, held);
    end
    pv = cv; pd = cd; ptag = tg;
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 0, '0, "R7");
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
  endtask

  initial begin
    rst_n = 1'b0; ren = 1'b0; wen = 1'b0; addr = '0; wdata = '0;
    pv = 1'b0; pd = '0; ptag = "R2"; held = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    nchk++;
    if (rvalid !== 1'b0 || rdata !== '0) begin
      nbad++;
      $display("FAIL R1 actual=%0b/%h expected=0/0", rvalid, rdata);
    end
    rst_n = 1'b1;

    // R8: fill the whole array, no reads outstanding.
    for (int a = 0; a < TB_DEPTH; a++) step(1'b0, 1'b1, a, patt(a, 0), "R8");
    // R3 R4: back-to-back read sweep.
    for (int a = 0; a < TB_DEPTH; a++) step(1'b1, 1'b0, a, '0, "R3 R4");
    idle(); idle();
    // Reverse-order back-to-back reads.
    for (int a = TB_DEPTH - 1; a >= 0; a--) step(1'b1, 1'b0, a, '0, "R4");
    idle();
    // R5: read and write the same word in one cycle, every row, back to back.
    for (int a = 0; a < TB_DEPTH; a++) step(1'b1, 1'b1, a, patt(a, 1), "R5");
    for (int a = 0; a < TB_DEPTH; a++) step(1'b1, 1'b0, a, '0, "R5 R8");
    idle();
    // R6: write the row in the cycle after its read, then read it again.
    for (int a = 0; a < TB_DEPTH; a++) begin
      step(1'b1, 1'b0, a, '0, "R6");
      step(1'b0, 1'b1, a, patt(a, 2), "R6");
      step(1'b1, 1'b0, a, '0, "R8");
      if (a % 4 == 0) idle();
    end
    idle();
    // R9: reads with junk write data and wen low leave contents intact.
    for (int a = 0; a < TB_DEPTH; a++) step(1'b1, 1'b0, a, ~patt(a, 7), "R9");
    for (int a = 0; a < TB_DEPTH; a++) step(1'b1, 1'b0, a, '0, "R9");
    // Alternating read/idle gaps.
    for (int a = 0; a < TB_DEPTH; a++) step(a[0], 1'b0, a, '0, "R2");
    idle(); idle(); idle();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nbad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule